// File: doc/BRIEF.md
# Segment-Style Banked RAM Mapper

This block turns a 16-bit CPU address in the lower 32KB of the CPU's space into a 17-bit physical SRAM address. The CPU address splits into three parts. The nine lowest bits are an in-page offset and go straight through. The six bits above them are a segment number. The top bit tells the lower half of the space from the upper half. The block holds two 8-bit base registers, one for the stack area and one for general RAM. It adds the chosen base to the zero-extended segment number, and the 8-bit sum becomes the upper physical address bits. The carry out of that sum is dropped, so every mapping wraps inside 128KB.

The segment number picks the base register. When all six segment bits are zero, the access falls in the lowest 512 bytes (zero page and stack) and the stack base applies. When any segment bit is set, the bank base applies. The CPU loads either base with a write while an external control-page select is high. Address bit 0 picks which base is loaded.

Translation is combinational and runs on every cycle, so no valid/ready handshake is needed and nothing can apply back-pressure. A base written on one clock edge steers translations from the next cycle on.

Top module: `bm_mapper`

## Requirements
- R1: After reset both bases are zero, so a lower-half address maps to itself: phys_addr[14:0] equals cpu_addr[14:0] and phys_addr[16:15] is zero.
- R2: ram_en is 1 exactly when cpu_addr[15] is 0.
- R3: phys_addr[8:0] always equals cpu_addr[8:0].
- R4: When cpu_addr[14:9] is all zero, phys_addr[16:9] equals the stack base (register index 0).
- R5: When any bit of cpu_addr[14:9] is 1, phys_addr[16:9] equals the bank base (register index 1) plus cpu_addr[14:9].
- R6: The sum that forms phys_addr[16:9] is taken modulo 256, and its carry out is discarded.
- R7: When cpu_wr=1, cfg_sel=1 and cpu_addr[0]=0 at a rising clock edge, the stack base takes cpu_wdata.
- R8: When cpu_wr=1, cfg_sel=1 and cpu_addr[0]=1 at a rising clock edge, the bank base takes cpu_wdata.
- R9: A cycle with cpu_wr=0 or cfg_sel=0 changes neither base, whatever cpu_wdata holds.
- R10: During a write cycle, phys_addr is formed from the base values held before that write. The new value first shows in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; base registers load on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears both bases |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cfg_sel | input | 1 | Control-register page select, decoded outside the block |
| cpu_wdata | input | 8 | CPU write data |
| phys_addr | output | 17 | Physical SRAM address |
| ram_en | output | 1 | High when the access falls in the lower half |

## Verification
A base-register write and an address translation can happen in the same cycle, because the write cycle presents an address that is also being translated. The bench provokes this with writes whose address lies in the lower half: one targets the base that the presented segment uses, and another targets the base it does not use. In the write cycle the scoreboard expects the translation made with the old base, and in the next cycle it expects the translation made with the new one. Carry wrap is provoked by pairing a large bank base with the top segment.

// File: rtl/bm_pkg.sv
package bm_pkg;
  // Number of base registers, addressed by the low CPU address bits.
  localparam int NUM_BASES = 2;
  localparam int STACK_IDX = 0;
  localparam int BANK_IDX  = 1;

  typedef enum logic {
    RGN_STACK = 1'b0,
    RGN_BANK  = 1'b1
  } region_e;
endpackage

// File: rtl/bm_base_regs.sv
module bm_base_regs #(
  parameter int BANK_W = 8,
  parameter int NREG   = 2,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [BANK_W-1:0]            wr_data,
  output logic [NREG-1:0][BANK_W-1:0]  base_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_base
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   base_q[g] <= '0;
      else if (hit) base_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/bm_region.sv
module bm_region #(
  parameter int SEG_W = 6
) (
  input  logic [SEG_W-1:0] seg,
  output bm_pkg::region_e  rgn
);
  // Segment zero is the zero-page / stack area; anything else is banked.
  assign rgn = (|seg) ? bm_pkg::RGN_BANK : bm_pkg::RGN_STACK;
endmodule

// File: rtl/bm_seg_add.sv
module bm_seg_add #(
  parameter int BANK_W = 8,
  parameter int SEG_W  = 6
) (
  input  logic [BANK_W-1:0] base,
  input  logic [SEG_W-1:0]  seg,
  output logic [BANK_W-1:0] sum
);
  // Segment is zero-extended; the carry out is dropped by the width.
  assign sum = base + BANK_W'(seg);
endmodule

// File: rtl/bm_mapper.sv
module bm_mapper #(
  parameter int OFS_W  = 9,
  parameter int SEG_W  = 6,
  parameter int BANK_W = 8,
  localparam int CPU_AW  = OFS_W + SEG_W + 1,
  localparam int PHYS_AW = OFS_W + BANK_W,
  localparam int NREG    = bm_pkg::NUM_BASES,
  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_wr,
  input  logic               cfg_sel,
  input  logic [BANK_W-1:0]  cpu_wdata,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic               ram_en
);
  logic [NREG-1:0][BANK_W-1:0] base_q;
  logic [SEG_W-1:0]            seg;
  logic [OFS_W-1:0]            ofs;
  bm_pkg::region_e             rgn;
  logic [BANK_W-1:0]           base_sel;
  logic [BANK_W-1:0]           upper;

  assign ofs = cpu_addr[OFS_W-1:0];
  assign seg = cpu_addr[OFS_W +: SEG_W];

  bm_base_regs #(.BANK_W(BANK_W), .NREG(NREG)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr && cfg_sel),
    .wr_idx  (cpu_addr[IDX_W-1:0]),
    .wr_data (cpu_wdata),
    .base_q  (base_q)
  );

  bm_region #(.SEG_W(SEG_W)) i_region (
    .seg (seg),
    .rgn (rgn)
  );

  assign base_sel = (rgn == bm_pkg::RGN_BANK) ? base_q[bm_pkg::BANK_IDX]
                                              : base_q[bm_pkg::STACK_IDX];

  bm_seg_add #(.BANK_W(BANK_W), .SEG_W(SEG_W)) i_add (
    .base (base_sel),
    .seg  (seg),
    .sum  (upper)
  );

  assign phys_addr = {upper, ofs};
  assign ram_en    = ~cpu_addr[CPU_AW-1];
endmodule

// File: rtl/bm_mapper_chk.sv
module bm_mapper_chk #(
  parameter int OFS_W  = 9,
  parameter int SEG_W  = 6,
  parameter int BANK_W = 8,
  localparam int CPU_AW  = OFS_W + SEG_W + 1,
  localparam int PHYS_AW = OFS_W + BANK_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic               cpu_wr,
  input logic               cfg_sel,
  input logic [BANK_W-1:0]  cpu_wdata,
  input logic [PHYS_AW-1:0] phys_addr,
  input logic               ram_en
);
  logic [BANK_W-1:0] m_stack, m_bank;
  logic [SEG_W-1:0]  m_seg;
  assign m_seg = cpu_addr[OFS_W +: SEG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_stack <= '0;
      m_bank  <= '0;
    end else if (cpu_wr && cfg_sel) begin
      if (cpu_addr[0]) m_bank  <= cpu_wdata;
      else             m_stack <= cpu_wdata;
    end
  end

  a_r2_ram_en: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en == !cpu_addr[CPU_AW-1]);

  a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);

  a_r4_stack_base: assert property (@(posedge clk) disable iff (!rst_n)
    (m_seg == '0) |-> (phys_addr[PHYS_AW-1:OFS_W] == m_stack));

  a_r5_bank_base: assert property (@(posedge clk) disable iff (!rst_n)
    (m_seg != '0) |-> (phys_addr[PHYS_AW-1:OFS_W] == BANK_W'(m_bank + BANK_W'(m_seg))));

  a_r9_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cpu_wr && cfg_sel) ##1 $stable(cpu_addr)) |-> $stable(phys_addr));
endmodule

bind bm_mapper bm_mapper_chk #(.OFS_W(OFS_W), .SEG_W(SEG_W), .BANK_W(BANK_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .cfg_sel   (cfg_sel),
  .cpu_wdata (cpu_wdata),
  .phys_addr (phys_addr),
  .ram_en    (ram_en)
);

// File: tb/test_bm_mapper.sv
`timescale 1ns/1ps
module test_bm_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [16:0] phys_addr;
  logic        ram_en;

  always #2.5 clk = ~clk;

  bm_mapper i_bm_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cfg_sel(cfg_sel), .cpu_wdata(cpu_wdata), .phys_addr(phys_addr), .ram_en(ram_en)
  );

  typedef struct {
    logic [16:0] phys;
    logic        en;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  logic [7:0] s_base = '0;
  logic [7:0] b_base = '0;
  bit   done = 0;

  // Driver: presents one cycle of stimulus and pushes the expected output.
  task automatic apply(input logic [15:0] a, input logic wr, input logic sel,
                       input logic [7:0] d, input string tag);
    exp_t e;
    logic [5:0] sg;
    logic [7:0] up;
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cfg_sel = sel; cpu_wdata = d;
    sg = a[14:9];
    up = (sg == 6'd0) ? s_base : 8'(b_base + {2'b00, sg});
    e.phys = {up, a[8:0]};
    e.en   = ~a[15];
    e.tag  = tag;
    q.push_back(e);
    if (wr && sel) begin
      if (a[0]) b_base = d;
      else      s_base = d;
    end
  endtask

  // Monitor: compares outputs mid-cycle against the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (phys_addr !== e.phys || ram_en !== e.en) begin
          n_bad++;
          $display("FAIL %s: phys=%05h en=%b expected phys=%05h en=%b",
                   e.tag, phys_addr, ram_en, e.phys, e.en);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: identity after reset
    apply(16'h0000, 0, 0, 8'h00, "R1 identity zero");
    apply(16'h0123, 0, 0, 8'h00, "R1 identity stack area");
    apply(16'h7FFF, 0, 0, 8'h00, "R1 identity top of low half");
    // R2: upper half deasserts ram_en
    apply(16'h8000, 0, 0, 8'h00, "R2 upper half");
    apply(16'hFFFF, 0, 0, 8'h00, "R2 upper half top");
    // R7: load stack base through a control-page write (A0=0)
    apply(16'h8000, 1, 1, 8'h05, "R7 stack write cycle");
    apply(16'h01FF, 0, 0, 8'h00, "R7 R4 stack base applied");
    apply(16'h0000, 0, 0, 8'h00, "R4 stack base at zero");
    // R8: load bank base (A0=1)
    apply(16'h8001, 1, 1, 8'h10, "R8 bank write cycle");
    apply(16'h0200, 0, 0, 8'h00, "R8 R5 bank base seg1");
    apply(16'h0155, 0, 0, 8'h00, "R4 stack base unchanged by bank write");
    apply(16'h4AB7, 0, 0, 8'h00, "R5 R3 bank base seg37 offset");
    // R9: writes without both strobes are ignored
    apply(16'h8000, 1, 0, 8'hEE, "R9 wr without select");
    apply(16'h8001, 0, 1, 8'hDD, "R9 select without wr");
    apply(16'h0000, 0, 0, 8'h00, "R9 stack base held");
    apply(16'h0200, 0, 0, 8'h00, "R9 bank base held");
    // R6: carry discarded
    apply(16'h8001, 1, 1, 8'hF0, "R8 bank write F0");
    apply(16'h7E00, 0, 0, 8'h00, "R6 wrap F0+3F");
    apply(16'h2000, 0, 0, 8'h00, "R6 wrap F0+10");
    // R10: write and translation in the same cycle
    apply(16'h0000, 1, 1, 8'h77, "R10 stack write old value seen");
    apply(16'h0000, 0, 0, 8'h00, "R10 stack new value next cycle");
    apply(16'h0401, 1, 1, 8'h20, "R10 bank write old value seen");
    apply(16'h0401, 0, 0, 8'h00, "R10 bank new value next cycle");
    apply(16'h0200, 1, 1, 8'h33, "R10 write to unused base");
    apply(16'h0200, 0, 0, 8'h00, "R10 R4 other base unaffected");
    apply(16'h0000, 0, 0, 8'h00, "R7 stack from lower-half write");
    // R1: reset restores identity
    @(negedge clk); rst_n = 1'b0; cpu_wr = 1'b0; cfg_sel = 1'b0;
    @(negedge clk);
    s_base = '0; b_base = '0;
    rst_n = 1'b1;
    apply(16'h0000, 0, 0, 8'h00, "R1 identity after second reset");
    apply(16'h5C3A, 0, 0, 8'h00, "R1 identity banked after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule